// File: doc/BRIEF.md
# Boot Mode Entry Detector

This block watches two device pins, a reset pin and an active-low program-store strobe pin. It decides how the device comes out of reset: in normal run mode, or in external-host programming mode. Both pins first pass through a two-stage synchroniser. They are then sampled once per machine cycle, which is a fixed count of system clocks produced by an internal divider. The block drives three outputs:

- an internal core reset;
- a flag that records the chosen mode;
- a one-clock strobe marking the moment the decision is made.

A short glitch on the reset pin never resets the core. A qualified falling edge on the strobe pin during a long reset selects host mode. Any other reset sequence returns the device to run mode. The decision is taken when the reset pin is released. It then stays in force until the next release. This block carries no data stream, so all its pins are plain control and status signals without a handshake.

Top module: `boot_mode_detect`

## Requirements
- R1: Both pins are sampled once per machine cycle of `CLKS_PER_MC` clocks (default 12), after a two-stage synchroniser. A reset-pin high pulse that covers only one sample point (for example exactly 12 clocks wide) never asserts `core_rst`.
- R2: `core_rst` goes high at the sample where the reset pin has been seen high on two consecutive samples. It stays high while the samples remain high.
- R3: A strobe falling edge (strobe sampled 1, then sampled 0 on the next sample) qualifies only if the reset pin has been high on at least 11 consecutive samples, counting the sample that shows strobe low. An edge before that point is ignored, even if the reset pin stays high afterwards. If reset drops without a qualified edge, run mode is chosen.
- R4: Once a qualified edge is seen, it is remembered until release, even if the strobe returns high. A strobe held low throughout the reset, with no 1-to-0 sample transition, does not select host mode.
- R5: On the first sample that shows the reset pin low while `core_rst` is high, `core_rst` falls. At the same clock edge `host_mode` is loaded (1 = external-host mode, 0 = run mode) and `mode_valid` goes high.
- R6: `mode_valid` is high for exactly one clock per release.
- R7: `host_mode` changes only at a release. Its value is held through any later reset until that reset releases.
- R8: While `arst_n` is low, and right after it rises, `core_rst`, `host_mode` and `mode_valid` are all 0.
- R9: Strobe activity while `core_rst` is low changes none of the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous power-up reset, active low |
| rst_pin | input | 1 | Raw device reset pin, active high, asynchronous to clk |
| prog_strobe_n | input | 1 | Raw program-store strobe pin, active low, asynchronous to clk |
| core_rst | output | 1 | Qualified internal reset, active high |
| host_mode | output | 1 | 1 = external-host programming mode chosen, 0 = run mode |
| mode_valid | output | 1 | One-clock pulse when the mode is decided at reset release |

## Verification
Two decisions can land on the same sample: the strobe edge detector firing, and the reset hold counter reaching its threshold. The bench aligns itself to the clock edge where `core_rst` rises, which is known to be the second reset sample. It then drops the strobe so that the edge is first seen on sample 10 in one run and on sample 11 in another. Only the second run must report host mode at release.

// File: rtl/boot_mode_pkg.sv
package boot_mode_pkg;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_HELD = 1'b1
  } hold_state_e;

  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/bm_mc_divider.sv
module bm_mc_divider #(
  parameter int unsigned CLKS_PER_MC = 12
) (
  input  logic clk,
  input  logic arst_n,
  output logic tick
);
  localparam int unsigned CW = boot_mode_pkg::cnt_w(CLKS_PER_MC);
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_MC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)          cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);
endmodule

// File: rtl/bm_pin_sync.sv
module bm_pin_sync #(
  parameter int unsigned     WIDTH  = 1,
  parameter int unsigned     STAGES = 2,
  parameter logic [WIDTH-1:0] INIT  = '0
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] r;
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) r <= INIT;
        else         r <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) r <= INIT;
        else         r <= g_stage[s-1].r;
      end
    end
  end

  assign q = g_stage[STAGES-1].r;
endmodule

// File: rtl/bm_entry_fsm.sv
module bm_entry_fsm
  import boot_mode_pkg::*;
#(
  parameter int unsigned RST_QUAL_MC = 2,
  parameter int unsigned HOLD_MC     = 10
) (
  input  logic clk,
  input  logic arst_n,
  input  logic tick,
  input  logic rst_s,
  input  logic strb_s,
  output logic core_rst,
  output logic host_mode,
  output logic mode_valid
);
  localparam int unsigned SAT = (HOLD_MC > RST_QUAL_MC) ? HOLD_MC : RST_QUAL_MC;
  localparam int unsigned HW  = cnt_w(SAT + 1);
  localparam logic [HW-1:0] SAT_V   = HW'(SAT);
  localparam logic [HW-1:0] QUAL_V  = HW'(RST_QUAL_MC - 1);
  localparam logic [HW-1:0] HOLD_V  = HW'(HOLD_MC);

  hold_state_e state;
  logic [HW-1:0] hi_cnt;     // consecutive high reset samples before this one
  logic          strb_prev;
  logic          pend;
  logic          edge_seen;
  logic          hold_met;
  logic          qual_met;

  assign edge_seen = strb_prev & ~strb_s;
  assign hold_met  = (hi_cnt >= HOLD_V);
  assign qual_met  = (hi_cnt >= QUAL_V);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state      <= ST_RUN;
      hi_cnt     <= '0;
      strb_prev  <= 1'b1;
      pend       <= 1'b0;
      host_mode  <= 1'b0;
      mode_valid <= 1'b0;
    end else begin
      mode_valid <= 1'b0;
      if (tick) begin
        strb_prev <= strb_s;
        if (rst_s) begin
          if (hi_cnt != SAT_V) hi_cnt <= hi_cnt + 1'b1;
          if (qual_met)        state  <= ST_HELD;
          if (edge_seen && hold_met) pend <= 1'b1;
        end else begin
          hi_cnt <= '0;
          pend   <= 1'b0;
          if (state == ST_HELD) begin
            state      <= ST_RUN;
            host_mode  <= pend;
            mode_valid <= 1'b1;
          end
        end
      end
    end
  end

  assign core_rst = (state == ST_HELD);
endmodule

// File: rtl/boot_mode_detect.sv
module boot_mode_detect #(
  parameter int unsigned CLKS_PER_MC = 12,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_QUAL_MC = 2,
  parameter int unsigned HOLD_MC     = 10
) (
  input  logic clk,
  input  logic arst_n,
  input  logic rst_pin,
  input  logic prog_strobe_n,
  output logic core_rst,
  output logic host_mode,
  output logic mode_valid
);
  logic       mc_tick;
  logic [1:0] pins_q;
  logic       rst_q;
  logic       strb_q;

  bm_mc_divider #(.CLKS_PER_MC(CLKS_PER_MC)) u_div (
    .clk    (clk),
    .arst_n (arst_n),
    .tick   (mc_tick)
  );

  bm_pin_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .INIT(2'b10)) u_sync (
    .clk    (clk),
    .arst_n (arst_n),
    .d      ({prog_strobe_n, rst_pin}),
    .q      (pins_q)
  );

  assign rst_q  = pins_q[0];
  assign strb_q = pins_q[1];

  bm_entry_fsm #(.RST_QUAL_MC(RST_QUAL_MC), .HOLD_MC(HOLD_MC)) u_fsm (
    .clk        (clk),
    .arst_n     (arst_n),
    .tick       (mc_tick),
    .rst_s      (rst_q),
    .strb_s     (strb_q),
    .core_rst   (core_rst),
    .host_mode  (host_mode),
    .mode_valid (mode_valid)
  );
endmodule

// File: rtl/boot_mode_detect_chk.sv
module boot_mode_detect_chk (
  input logic clk,
  input logic arst_n,
  input logic tick,
  input logic rst_s,
  input logic core_rst,
  input logic host_mode,
  input logic mode_valid
);
  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!arst_n)
    tick |=> !tick);                                                  // R1
  AST_CORE_RST_ON_SAMPLE: assert property (@(posedge clk) disable iff (!arst_n)
    (core_rst != $past(core_rst)) |-> $past(tick));                   // R1
  AST_RST_RISE_NEEDS_PIN: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(core_rst) |-> ($past(tick) && $past(rst_s)));               // R2
  AST_VALID_AT_RELEASE: assert property (@(posedge clk) disable iff (!arst_n)
    mode_valid |-> $fell(core_rst));                                  // R5
  AST_VALID_ONE_CLK: assert property (@(posedge clk) disable iff (!arst_n)
    mode_valid |=> !mode_valid);                                      // R6
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!arst_n)
    !mode_valid |-> $stable(host_mode));                              // R7
  AST_HOST_AFTER_RESET: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(host_mode) |-> (mode_valid && !core_rst));                  // R4
  always_comb begin
    if (!arst_n) begin
      AST_QUIET_IN_RESET: assert (!core_rst && !mode_valid);          // R8
    end
  end
endmodule

bind boot_mode_detect boot_mode_detect_chk u_chk (
  .clk        (clk),
  .arst_n     (arst_n),
  .tick       (mc_tick),
  .rst_s      (rst_q),
  .core_rst   (core_rst),
  .host_mode  (host_mode),
  .mode_valid (mode_valid)
);

// File: tb/boot_mode_detect_test.sv
`timescale 1ns/1ps
module boot_mode_detect_test;
  localparam int MC = 12;

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic rst_pin = 1'b0;
  logic prog_strobe_n = 1'b1;
  logic core_rst, host_mode, mode_valid;

  int n_chk = 0;
  int n_bad = 0;
  int valid_cnt = 0;
  int rise_cnt = 0;
  logic last_host = 1'b0;
  logic core_q = 1'b0;

  always #2.5 clk = ~clk;

  boot_mode_detect uut (
    .clk           (clk),
    .arst_n        (arst_n),
    .rst_pin       (rst_pin),
    .prog_strobe_n (prog_strobe_n),
    .core_rst      (core_rst),
    .host_mode     (host_mode),
    .mode_valid    (mode_valid)
  );

  always @(negedge clk) begin
    if (mode_valid) begin
      valid_cnt++;
      last_host = host_mode;
    end
    if (core_rst && !core_q) rise_cnt++;
    core_q = core_rst;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_mc(input int n);
    repeat (n * MC) @(negedge clk);
  endtask

  task automatic wait_core_rise();
    while (!core_rst) @(negedge clk);
  endtask

  // reset pin held high long enough; strobe dropped j cycles after core reset rose
  task automatic host_entry_try(input int j, input logic exp_host, input string req);
    int v0;
    v0 = valid_cnt;
    rst_pin = 1'b1;
    wait_core_rise();
    wait_mc(j);
    prog_strobe_n = 1'b0;
    wait_mc(4);
    rst_pin = 1'b0;
    wait_mc(3);
    check({req, " one release"}, valid_cnt - v0, 1);
    check({req, " mode at release"}, int'(last_host), int'(exp_host));
    check({req, " core_rst low"}, int'(core_rst), 0);
    prog_strobe_n = 1'b1;
    wait_mc(2);
  endtask

  task automatic t_reset_state();
    check("R8 core_rst", int'(core_rst), 0);
    check("R8 host_mode", int'(host_mode), 0);
    check("R8 mode_valid", int'(mode_valid), 0);
  endtask

  task automatic t_short_pulse();
    int r0, v0;
    r0 = rise_cnt; v0 = valid_cnt;
    rst_pin = 1'b1;
    repeat (MC) @(negedge clk);
    rst_pin = 1'b0;
    wait_mc(4);
    check("R1 single-sample pulse no reset", rise_cnt - r0, 0);
    check("R1 single-sample pulse no valid", valid_cnt - v0, 0);
  endtask

  task automatic t_two_sample_pulse();
    int r0, v0;
    r0 = rise_cnt; v0 = valid_cnt;
    rst_pin = 1'b1;
    repeat (2 * MC) @(negedge clk);
    rst_pin = 1'b0;
    wait_mc(4);
    check("R2 two-sample pulse resets", rise_cnt - r0, 1);
    check("R6 one valid clock", valid_cnt - v0, 1);
    check("R5 run mode", int'(last_host), 0);
  endtask

  task automatic t_early_edge_long_hold();
    int v0;
    v0 = valid_cnt;
    rst_pin = 1'b1;
    wait_mc(3);
    prog_strobe_n = 1'b0;
    wait_mc(20);
    check("R2 core_rst held", int'(core_rst), 1);
    rst_pin = 1'b0;
    wait_mc(3);
    check("R3 early edge ignored", int'(last_host), 0);
    check("R3 release count", valid_cnt - v0, 1);
    prog_strobe_n = 1'b1;
    wait_mc(2);
  endtask

  task automatic t_early_drop();
    rst_pin = 1'b1;
    wait_mc(3);
    prog_strobe_n = 1'b0;
    wait_mc(4);
    rst_pin = 1'b0;
    wait_mc(3);
    check("R3 reset dropped before hold", int'(host_mode), 0);
    prog_strobe_n = 1'b1;
    wait_mc(2);
  endtask

  task automatic t_strobe_when_idle();
    int v0;
    v0 = valid_cnt;
    for (int k = 0; k < 3; k++) begin
      prog_strobe_n = 1'b0;
      wait_mc(2);
      prog_strobe_n = 1'b1;
      wait_mc(2);
    end
    check("R9 no valid from idle strobe", valid_cnt - v0, 0);
    check("R9 host_mode kept", int'(host_mode), 1);
    check("R9 core_rst low", int'(core_rst), 0);
  endtask

  task automatic t_hold_through_reset();
    rst_pin = 1'b1;
    wait_mc(6);
    check("R7 core_rst during reset", int'(core_rst), 1);
    check("R7 host_mode held in reset", int'(host_mode), 1);
    rst_pin = 1'b0;
    wait_mc(3);
    check("R7 new decision run", int'(host_mode), 0);
  endtask

  task automatic t_strobe_back_high();
    rst_pin = 1'b1;
    wait_core_rise();
    wait_mc(10);
    prog_strobe_n = 1'b0;
    wait_mc(2);
    prog_strobe_n = 1'b1;
    wait_mc(5);
    rst_pin = 1'b0;
    wait_mc(3);
    check("R4 qualified edge remembered", int'(host_mode), 1);
  endtask

  task automatic t_strobe_always_low();
    prog_strobe_n = 1'b0;
    wait_mc(2);
    rst_pin = 1'b1;
    wait_mc(20);
    rst_pin = 1'b0;
    wait_mc(3);
    check("R4 no transition means run", int'(host_mode), 0);
    prog_strobe_n = 1'b1;
    wait_mc(2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    arst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    wait_mc(2);
    t_short_pulse();
    t_two_sample_pulse();
    host_entry_try(7, 1'b0, "R3 edge on sample 10");
    host_entry_try(8, 1'b1, "R3 edge on sample 11");
    t_strobe_when_idle();
    t_hold_through_reset();
    t_early_edge_long_hold();
    t_early_drop();
    t_strobe_back_high();
    t_strobe_always_low();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule